// File: doc/BRIEF.md
# Soft-Start and Fault Sequencer

This block is the digital controller that brings the outputs of a multi-rail regulator up, restarts them, and takes them down under fault. A saturating ramp counter stands in for the soft-start capacitor voltage. Once all three supply power-on-reset flags are valid, the counter jumps to a quarter of full scale and then climbs by a fixed step each clock. PWM switching is permitted only while the ramp is above a configurable valley level.

Over-current trips are counted. The first trip discharges the ramp at once and then restarts it. A later trip keeps the outputs off while the ramp completes its climb, then discharges and restarts. The trip that reaches the limit sets a latched fault. An over-voltage sets the fault directly, without going through the counter. A linear under-voltage is blanked until the ramp has finished, and after that it counts as a trip. Shutdown, loss of the bias power-on-reset, and a supply under-voltage each take the outputs down, as set out below.

Top module: `ssq_top`

## Requirements
- R1: While any bit of `por_ok_i` is low, after the next edge `ramp_o` is 0 and `out_en_o` and `ramp_done_o` are low. No ramp starts until all three bits are high.
- R2: On the first edge with all power-on-reset bits high, shutdown low and no fault, `ramp_o` loads PRESET = 2^RAMP_W/4 (64 by default) and `out_en_o` rises. Each later edge adds STEP (8), saturating at FULL = 2^RAMP_W-1 (255).
- R3: `ramp_done_o` rises on the edge on which a normal start reaches FULL, and it stays high while running.
- R4: `pwm_ok_o` is high exactly when `out_en_o` is high and `ramp_o` is greater than VALLEY (96).
- R5: A trip while the outputs are enabled increments `oc_count_o` and drops `out_en_o`. If the count was 0, the ramp falls by DSTEP (8) per edge down to 0, then reloads PRESET and restarts.
- R6: A trip that leaves the count at 2 or more but below OC_LIMIT keeps the outputs off while the ramp rises to FULL. The ramp then discharges to 0 and restarts.
- R7: The trip that brings the count to OC_LIMIT (3) sets `fault_o`. With the fault set, the outputs stay off and the ramp discharges to 0 and stays there.
- R8: `ov_i` high while all power-on-reset bits are high and shutdown is low sets `fault_o` on the next edge, whatever the count.
- R9: `luv_i` has no effect while `ramp_done_o` is low. While it is high, `luv_i` acts as a trip.
- R10: `shdn_i` high drops the outputs, discharges the ramp, and clears both the count and the fault. After release, once the ramp is at 0, a fresh start begins.
- R11: Bit 0 of `por_ok_i` is the bias flag. Its loss clears the count and the fault. Loss of bit 1 or bit 2 alone keeps the fault.
- R12: `supply_uv_i` high while starting or running drops the outputs and discharges the ramp. The count is unchanged. Restart (reload PRESET) follows once the flag is low and the ramp is at 0.
- R13: Trip inputs are ignored while the outputs are disabled, so `oc_count_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok_i | input | 3 | Supply power-on-reset valid flags, bit 0 = bias |
| shdn_i | input | 1 | Shutdown request for the controlled rails |
| oc_pulse_i | input | 1 | Core over-current trip pulse |
| ov_i | input | 1 | Core over-voltage level |
| luv_i | input | 1 | Linear output under-voltage level |
| supply_uv_i | input | 1 | Input supply under-voltage level |
| ramp_o | output | RAMP_W | Soft-start ramp value |
| out_en_o | output | 1 | Controlled outputs enabled (low = inhibit) |
| pwm_ok_o | output | 1 | PWM switching permitted |
| ramp_done_o | output | 1 | Ramp complete, running |
| oc_count_o | output | CNT_W | Over-current trip count |
| fault_o | output | 1 | Latched fault |

## Verification
The bound checker enforces rules that hold on every cycle:
- the idle state while power-on-reset is missing,
- the size limit on any rise of the ramp,
- that done implies full scale,
- the permit gating,
- that the fault keeps the outputs off,
- the immediate effect of over-voltage, shutdown and bias loss,
- that the count moves only by one or back to zero,
- the blanking of the linear under-voltage.

Only the bench's scenarios show the sequences: the first-trip, later-trip and limit-trip restart patterns, the fault surviving a non-bias power-on-reset loss, and the restart timing after a supply under-voltage. A cycle model of the requirements is compared against every output throughout the directed and random phases.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_CHARGE = 3'd1,
      ST_RUN    = 3'd2,
      ST_DISCH  = 3'd3,
      ST_HOLD   = 3'd4,
      ST_FAULT  = 3'd5
   } ssq_state_e;

   typedef enum logic [2:0] {
      RC_KEEP = 3'd0,
      RC_ZERO = 3'd1,
      RC_LOAD = 3'd2,
      RC_UP   = 3'd3,
      RC_DOWN = 3'd4
   } ramp_cmd_e;

endpackage

// File: rtl/ssq_ramp.sv
module ssq_ramp
   import ssq_pkg::*;
#(
   parameter int RAMP_W = 8,
   parameter int STEP   = 8,
   parameter int DSTEP  = 8,
   parameter int PRESET = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ramp_cmd_e         cmd_i,
   output logic [RAMP_W-1:0] ramp_o,
   output logic              at_zero_o,
   output logic              at_full_o,
   output logic              near_full_o
);

   localparam logic [RAMP_W:0]   FULL_X   = (RAMP_W+1)'((1 << RAMP_W) - 1);
   localparam logic [RAMP_W:0]   STEP_X   = (RAMP_W+1)'(STEP);
   localparam logic [RAMP_W:0]   DSTEP_X  = (RAMP_W+1)'(DSTEP);
   localparam logic [RAMP_W-1:0] PRESET_V = RAMP_W'(PRESET);

   logic [RAMP_W-1:0] ramp_q;
   logic [RAMP_W-1:0] ramp_d;
   logic [RAMP_W:0]   up_sum;
   logic [RAMP_W-1:0] up_val;
   logic [RAMP_W-1:0] dn_val;

   // charge and discharge paths, both clamped at the rails
   always_comb begin
      up_sum = {1'b0, ramp_q} + STEP_X;
      up_val = (up_sum >= FULL_X) ? FULL_X[RAMP_W-1:0] : up_sum[RAMP_W-1:0];
      dn_val = ({1'b0, ramp_q} > DSTEP_X) ? (ramp_q - DSTEP_X[RAMP_W-1:0]) : '0;
   end

   always_comb begin
      case (cmd_i)
         RC_ZERO: ramp_d = '0;
         RC_LOAD: ramp_d = PRESET_V;
         RC_UP:   ramp_d = up_val;
         RC_DOWN: ramp_d = dn_val;
         default: ramp_d = ramp_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ramp_q <= '0;
      else        ramp_q <= ramp_d;
   end

   assign ramp_o      = ramp_q;
   assign at_zero_o   = (ramp_q == '0);
   assign at_full_o   = (ramp_q == FULL_X[RAMP_W-1:0]);
   assign near_full_o = (up_sum >= FULL_X);

endmodule

// File: rtl/ssq_trip_cnt.sv
module ssq_trip_cnt #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   // clear wins over increment; saturates at the top code
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (clr_i)                   cnt_q <= '0;
      else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/ssq_ctrl.sv
module ssq_ctrl
   import ssq_pkg::*;
#(
   parameter int CNT_W    = 2,
   parameter int OC_LIMIT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             por_all_i,
   input  logic             por_bias_i,
   input  logic             shdn_i,
   input  logic             oc_i,
   input  logic             ov_i,
   input  logic             luv_i,
   input  logic             suv_i,
   input  logic             at_zero_i,
   input  logic             at_full_i,
   input  logic             near_full_i,
   input  logic [CNT_W-1:0] cnt_i,
   output ssq_state_e       state_o,
   output ramp_cmd_e        cmd_o,
   output logic             cnt_inc_o,
   output logic             cnt_clr_o,
   output logic             fault_o
);

   localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(OC_LIMIT);

   ssq_state_e       st_q, st_d;
   ramp_cmd_e        cmd;
   logic             fault_q, fault_set, fault_clr;
   logic             enabled, trip;
   logic [CNT_W-1:0] cnt_next;

   always_comb begin
      enabled  = (st_q == ST_CHARGE) || (st_q == ST_RUN);
      // linear under-voltage is only honoured once the ramp is done
      trip     = enabled && (oc_i || (luv_i && st_q == ST_RUN));
      cnt_next = cnt_i + 1'b1;
   end

   always_comb begin
      st_d      = st_q;
      cmd       = RC_KEEP;
      cnt_inc_o = 1'b0;
      fault_set = 1'b0;
      fault_clr = !por_bias_i || shdn_i;
      cnt_clr_o = !por_bias_i || shdn_i;

      if (!por_all_i) begin
         st_d = ST_IDLE;
         cmd  = RC_ZERO;
      end else if (shdn_i) begin
         st_d = ST_DISCH;
         cmd  = RC_DOWN;
      end else if (fault_q || ov_i) begin
         fault_set = ov_i;
         st_d      = ST_FAULT;
         cmd       = RC_DOWN;
      end else if (trip) begin
         cnt_inc_o = 1'b1;
         if (cnt_next == LIMIT_V) begin
            fault_set = 1'b1;
            st_d      = ST_FAULT;
            cmd       = RC_DOWN;
         end else if (cnt_i == '0) begin
            st_d = ST_DISCH;
            cmd  = RC_DOWN;
         end else begin
            st_d = ST_HOLD;
            cmd  = RC_UP;
         end
      end else begin
         case (st_q)
            ST_IDLE: begin
               st_d = ST_CHARGE;
               cmd  = RC_LOAD;
            end
            ST_CHARGE: begin
               if (suv_i) begin
                  st_d = ST_DISCH;
                  cmd  = RC_DOWN;
               end else begin
                  cmd = RC_UP;
                  if (near_full_i) st_d = ST_RUN;
               end
            end
            ST_RUN: begin
               if (suv_i) begin
                  st_d = ST_DISCH;
                  cmd  = RC_DOWN;
               end
            end
            ST_DISCH: begin
               if (at_zero_i && !suv_i) begin
                  st_d = ST_CHARGE;
                  cmd  = RC_LOAD;
               end else begin
                  cmd = RC_DOWN;
               end
            end
            ST_HOLD: begin
               if (at_full_i) begin
                  st_d = ST_DISCH;
                  cmd  = RC_DOWN;
               end else begin
                  cmd = RC_UP;
               end
            end
            default: begin
               st_d = ST_DISCH;
               cmd  = RC_DOWN;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         fault_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (fault_clr)      fault_q <= 1'b0;
         else if (fault_set) fault_q <= 1'b1;
      end
   end

   assign state_o = st_q;
   assign cmd_o   = cmd;
   assign fault_o = fault_q;

endmodule

// File: rtl/ssq_top.sv
module ssq_top
   import ssq_pkg::*;
#(
   parameter int RAMP_W   = 8,
   parameter int STEP     = 8,
   parameter int DSTEP    = STEP,
   parameter int VALLEY   = 96,
   parameter int CNT_W    = 2,
   parameter int OC_LIMIT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        por_ok_i,
   input  logic              shdn_i,
   input  logic              oc_pulse_i,
   input  logic              ov_i,
   input  logic              luv_i,
   input  logic              supply_uv_i,
   output logic [RAMP_W-1:0] ramp_o,
   output logic              out_en_o,
   output logic              pwm_ok_o,
   output logic              ramp_done_o,
   output logic [CNT_W-1:0]  oc_count_o,
   output logic              fault_o
);

   localparam int FULL   = (1 << RAMP_W) - 1;
   localparam int PRESET = (FULL + 1) / 4;
   localparam logic [RAMP_W-1:0] VALLEY_V = RAMP_W'(VALLEY);

   // elaboration-time parameter checks
   if (RAMP_W < 4 || RAMP_W > 16) begin : g_bad_w
      $error("ssq_top: RAMP_W out of range");
   end
   if (STEP < 1 || STEP >= FULL || DSTEP < 1 || DSTEP >= FULL) begin : g_bad_step
      $error("ssq_top: ramp step out of range");
   end
   if (VALLEY < 0 || VALLEY >= FULL) begin : g_bad_valley
      $error("ssq_top: VALLEY out of range");
   end
   if (OC_LIMIT < 1 || OC_LIMIT > (1 << CNT_W) - 1) begin : g_bad_lim
      $error("ssq_top: OC_LIMIT does not fit CNT_W");
   end

   ssq_state_e       state;
   ramp_cmd_e        cmd;
   logic             at_zero, at_full, near_full;
   logic             cnt_inc, cnt_clr;
   logic [CNT_W-1:0] cnt;

   ssq_ramp #(
      .RAMP_W (RAMP_W),
      .STEP   (STEP),
      .DSTEP  (DSTEP),
      .PRESET (PRESET)
   ) u_ramp (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_i       (cmd),
      .ramp_o      (ramp_o),
      .at_zero_o   (at_zero),
      .at_full_o   (at_full),
      .near_full_o (near_full)
   );

   ssq_trip_cnt #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (cnt_clr),
      .inc_i (cnt_inc),
      .cnt_o (cnt)
   );

   ssq_ctrl #(
      .CNT_W    (CNT_W),
      .OC_LIMIT (OC_LIMIT)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .por_all_i   (&por_ok_i),
      .por_bias_i  (por_ok_i[0]),
      .shdn_i      (shdn_i),
      .oc_i        (oc_pulse_i),
      .ov_i        (ov_i),
      .luv_i       (luv_i),
      .suv_i       (supply_uv_i),
      .at_zero_i   (at_zero),
      .at_full_i   (at_full),
      .near_full_i (near_full),
      .cnt_i       (cnt),
      .state_o     (state),
      .cmd_o       (cmd),
      .cnt_inc_o   (cnt_inc),
      .cnt_clr_o   (cnt_clr),
      .fault_o     (fault_o)
   );

   assign out_en_o    = (state == ST_CHARGE) || (state == ST_RUN);
   assign ramp_done_o = (state == ST_RUN);
   assign pwm_ok_o    = out_en_o && (ramp_o > VALLEY_V);
   assign oc_count_o  = cnt;

endmodule

// File: rtl/ssq_chk.sv
module ssq_chk #(
   parameter int RAMP_W = 8,
   parameter int STEP   = 8,
   parameter int VALLEY = 96,
   parameter int CNT_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        por_ok_i,
   input logic              shdn_i,
   input logic              oc_pulse_i,
   input logic              ov_i,
   input logic              luv_i,
   input logic              supply_uv_i,
   input logic [RAMP_W-1:0] ramp_o,
   input logic              out_en_o,
   input logic              pwm_ok_o,
   input logic              ramp_done_o,
   input logic [CNT_W-1:0]  oc_count_o,
   input logic              fault_o
);

   localparam logic [RAMP_W-1:0] FULL_V   = {RAMP_W{1'b1}};
   localparam logic [RAMP_W-1:0] PRESET_V = RAMP_W'(((1 << RAMP_W)) / 4);
   localparam logic [RAMP_W-1:0] STEP_V   = RAMP_W'(STEP);
   localparam logic [RAMP_W-1:0] VALLEY_V = RAMP_W'(VALLEY);

   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(&por_ok_i) |=> (ramp_o == '0 && !out_en_o && !ramp_done_o));

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ramp_o > $past(ramp_o)) |->
         ((ramp_o - $past(ramp_o) <= STEP_V) || ($past(ramp_o) == '0 && ramp_o == PRESET_V)));

   p_done_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ramp_done_o |-> (ramp_o == FULL_V && out_en_o));

   p_pwm_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_ok_o |-> (out_en_o && ramp_o > VALLEY_V));

   p_cnt_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_count_o != $past(oc_count_o)) |->
         (oc_count_o == '0 || oc_count_o == $past(oc_count_o) + 1'b1));

   p_fault_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> !out_en_o);

   p_ov_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (&por_ok_i && !shdn_i && ov_i) |=> fault_o);

   p_luv_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (&por_ok_i && !shdn_i && !ov_i && out_en_o && !ramp_done_o && luv_i && !oc_pulse_i)
         |=> $stable(oc_count_o));

   p_shdn_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      shdn_i |=> (!fault_o && oc_count_o == '0 && !out_en_o));

   p_bias_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !por_ok_i[0] |=> (!fault_o && oc_count_o == '0 && ramp_o == '0));

endmodule

bind ssq_top ssq_chk #(
   .RAMP_W (RAMP_W),
   .STEP   (STEP),
   .VALLEY (VALLEY),
   .CNT_W  (CNT_W)
) u_chk (.*);

// File: tb/tb_ssq_top.sv
`timescale 1ns/1ps
module tb_ssq_top;

   localparam int W      = 8;
   localparam int STEP   = 8;
   localparam int DSTEP  = 8;
   localparam int VALLEY = 96;
   localparam int OCL    = 3;
   localparam int FULL   = 255;
   localparam int PRE    = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] por = 3'b000;
   logic       shdn = 1'b0, oc = 1'b0, ov = 1'b0, luv = 1'b0, suv = 1'b0;
   logic [W-1:0] ramp;
   logic       en, pwm, done, flt;
   logic [1:0] cnt;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   // model state: 0 idle, 1 charge, 2 run, 3 discharge, 4 hold, 5 fault
   int m_st = 0, m_ramp = 0, m_cnt = 0;
   bit m_flt = 1'b0;

   always #5 clk = ~clk;

   ssq_top dut (
      .clk(clk), .rst_n(rst_n), .por_ok_i(por), .shdn_i(shdn),
      .oc_pulse_i(oc), .ov_i(ov), .luv_i(luv), .supply_uv_i(suv),
      .ramp_o(ramp), .out_en_o(en), .pwm_ok_o(pwm), .ramp_done_o(done),
      .oc_count_o(cnt), .fault_o(flt)
   );

   function automatic int up_f(int r);
      return (r + STEP >= FULL) ? FULL : r + STEP;
   endfunction

   function automatic int dn_f(int r);
      return (r > DSTEP) ? r - DSTEP : 0;
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_step();
      int nr = m_ramp, ns = m_st, nc = m_cnt;
      bit nf = m_flt;
      bit trip;
      if (!rst_n) begin
         m_st = 0; m_ramp = 0; m_cnt = 0; m_flt = 0;
         return;
      end
      trip = (m_st == 1 || m_st == 2) && (oc || (luv && m_st == 2));
      if (!(&por)) begin ns = 0; nr = 0; end
      else if (shdn) begin ns = 3; nr = dn_f(m_ramp); end
      else if (m_flt || ov) begin ns = 5; nr = dn_f(m_ramp); if (ov) nf = 1; end
      else if (trip) begin
         nc = m_cnt + 1;
         if (nc == OCL) begin nf = 1; ns = 5; nr = dn_f(m_ramp); end
         else if (m_cnt == 0) begin ns = 3; nr = dn_f(m_ramp); end
         else begin ns = 4; nr = up_f(m_ramp); end
      end else begin
         case (m_st)
            0: begin ns = 1; nr = PRE; end
            1: if (suv) begin ns = 3; nr = dn_f(m_ramp); end
               else begin nr = up_f(m_ramp); if (m_ramp + STEP >= FULL) ns = 2; end
            2: if (suv) begin ns = 3; nr = dn_f(m_ramp); end
            3: if (m_ramp == 0 && !suv) begin ns = 1; nr = PRE; end
               else nr = dn_f(m_ramp);
            4: if (m_ramp == FULL) begin ns = 3; nr = dn_f(m_ramp); end
               else nr = up_f(m_ramp);
            default: begin ns = 3; nr = dn_f(m_ramp); end
         endcase
      end
      if (!por[0] || shdn) begin nc = 0; nf = 0; end
      m_st = ns; m_ramp = nr; m_cnt = nc; m_flt = nf;
   endtask

   task automatic compare();
      bit m_en = (m_st == 1 || m_st == 2);
      chk("R2 ramp model", int'(ramp), m_ramp);
      chk("R5 out_en model", int'(en), int'(m_en));
      chk("R3 done model", int'(done), int'(m_st == 2));
      chk("R4 pwm model", int'(pwm), int'(m_en && m_ramp > VALLEY));
      chk("R6 count model", int'(cnt), m_cnt);
      chk("R7 fault model", int'(flt), int'(m_flt));
   endtask

   task automatic cycle();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
   endtask

   task automatic wait_done();
      for (int i = 0; i < 200 && !done; i++) cycle();
   endtask

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      for (int i = 0; i < 4; i++) cycle();
      chk("R1 reset ramp", int'(ramp), 0);
      chk("R1 reset fault", int'(flt), 0);
      rst_n = 1'b1;
      por = 3'b011;
      for (int i = 0; i < 5; i++) cycle();
      chk("R1 waits for por ramp", int'(ramp), 0);
      chk("R1 waits for por en", int'(en), 0);

      por = 3'b111;
      cycle();
      chk("R2 preset load", int'(ramp), PRE);
      chk("R2 enable", int'(en), 1);
      cycle();
      chk("R2 first step", int'(ramp), PRE + STEP);
      chk("R4 below valley", int'(pwm), 0);

      luv = 1'b1;
      for (int i = 0; i < 3; i++) cycle();
      luv = 1'b0;
      chk("R9 luv blanked count", int'(cnt), 0);
      chk("R9 luv blanked en", int'(en), 1);
      chk("R4 at valley", int'(pwm), 0);
      cycle();
      chk("R4 above valley", int'(pwm), 1);

      wait_done();
      chk("R3 done at full", int'(ramp), FULL);

      luv = 1'b1; cycle(); luv = 1'b0;
      chk("R9 luv trips", int'(cnt), 1);
      chk("R5 first trip inhibits", int'(en), 0);
      chk("R5 first trip discharges", int'(ramp), FULL - DSTEP);

      wait_done();
      oc = 1'b1; cycle(); oc = 1'b0;
      chk("R6 second trip count", int'(cnt), 2);
      chk("R6 hold inhibits", int'(en), 0);
      chk("R6 hold at full", int'(ramp), FULL);
      cycle();
      chk("R6 then discharges", int'(ramp), FULL - DSTEP);

      wait_done();
      oc = 1'b1; cycle(); oc = 1'b0;
      chk("R7 limit count", int'(cnt), 3);
      chk("R7 fault set", int'(flt), 1);
      oc = 1'b1; cycle(); oc = 1'b0;
      chk("R13 ignored trip", int'(cnt), 3);
      for (int i = 0; i < 40; i++) cycle();
      chk("R7 ramp zero", int'(ramp), 0);
      chk("R7 fault held", int'(flt), 1);

      shdn = 1'b1; cycle();
      chk("R10 fault cleared", int'(flt), 0);
      chk("R10 count cleared", int'(cnt), 0);
      for (int i = 0; i < 5; i++) cycle();
      chk("R10 outputs off", int'(en), 0);
      shdn = 1'b0; cycle();
      chk("R10 restart preset", int'(ramp), PRE);

      wait_done();
      ov = 1'b1; cycle(); ov = 1'b0;
      chk("R8 ov fault", int'(flt), 1);
      chk("R8 count untouched", int'(cnt), 0);

      por = 3'b101; cycle();
      chk("R11 nonbias keeps fault", int'(flt), 1);
      chk("R1 ramp cleared", int'(ramp), 0);
      por = 3'b111; cycle();
      chk("R11 fault persists", int'(flt), 1);
      por = 3'b110; cycle();
      chk("R11 bias clears fault", int'(flt), 0);
      por = 3'b111; cycle();
      chk("R2 restart after bias", int'(ramp), PRE);

      wait_done();
      suv = 1'b1; cycle();
      chk("R12 uv inhibits", int'(en), 0);
      chk("R12 uv discharges", int'(ramp), FULL - DSTEP);
      for (int i = 0; i < 40; i++) cycle();
      chk("R12 held at zero", int'(ramp), 0);
      chk("R12 count unchanged", int'(cnt), 0);
      suv = 1'b0; cycle();
      chk("R12 restart", int'(ramp), PRE);

      // constrained random phase, checked against the model each cycle
      for (int n = 0; n < 20000; n++) begin
         oc  = ($urandom_range(0, 59) == 0);
         luv = ($urandom_range(0, 39) == 0);
         ov  = ($urandom_range(0, 2999) == 0);
         if ($urandom_range(0, 399) == 0) shdn = ~shdn;
         if ($urandom_range(0, 499) == 0) suv = ~suv;
         for (int b = 0; b < 3; b++) begin
            if (!por[b] && $urandom_range(0, 19) == 0) por[b] = 1'b1;
            else if ($urandom_range(0, 1499) == 0)     por[b] = 1'b0;
         end
         cycle();
      end

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!finished) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule